// File: doc/BRIEF.md
# DTMF Tone-Pair Frequency Decoder

This block receives two square waves, one carrying the low-group tone and one carrying the high-group tone. Each has already been band-split and limited to full logic swing. For each input it counts reference-clock cycles between rising edges and adds up a fixed number of consecutive periods. It compares that sum against acceptance windows built at elaboration time around the nominal sum of each of the four tones in that group. A group is valid when exactly one window matches and edges keep arriving.

When both groups are valid in the same cycle, the block raises an early-steering flag and loads a 4-bit code for the pair. The flag is a raw two-tone indication. Checking how long the pair lasts is left to a downstream steering stage. An inhibit input suppresses the four extended characters, which are the pairs whose high tone is the highest column. The code output keeps its last value whenever the flag is low.

Top module: `dtmf_pair_decoder`

## Requirements
- R1: A synchronous active-high reset clears the flag `est` to 0 and the output `code` to 0.
- R2: The low rows are 697, 770, 852 and 941 Hz (row index 0 to 3). The high columns are 1209, 1336, 1477 and 1633 Hz (column index 0 to 3). A steady pair of nominal tones raises `est` and sets `code` = row*4 + col, with row in bits 3:2 and column in bits 1:0.
- R3: `est` is high only in cycles where both groups hold a valid tone. A tone in only one group never raises it.
- R4: If a group sees no rising edge for twice the nominal period of that group's lowest tone, the group becomes invalid and `est` falls.
- R5: A tone is accepted when the sum of `NAVG` periods lies within ±`TOL_PERMILLE`/1000 of the nominal sum. With the default 2.5 % tolerance, a tone 1 % off nominal is decoded and a tone 6 % off any nominal is rejected.
- R6: A group becomes valid only after one arming edge followed by `NAVG` complete periods. A burst shorter than that never raises `est`.
- R7: While `inhibit` is high, pairs with column index 3 (codes 3, 7, 11, 15) do not raise `est` and leave `code` unchanged. Raising `inhibit` during such a pair drops `est` on the next clock. Other columns are unaffected.
- R8: `code` changes only in a cycle in which `est` is high. It holds its value while `est` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that periods are counted against |
| rst | input | 1 | Synchronous reset, active high |
| lo_tone | input | 1 | Limited low-group tone, asynchronous |
| hi_tone | input | 1 | Limited high-group tone, asynchronous |
| inhibit | input | 1 | High blocks the four column-3 characters |
| est | output | 1 | Early-steering flag: both groups valid |
| code | output | 4 | Code of the last accepted pair, {row, col} |

## Verification
The bench sweeps all sixteen nominal pairs, each followed by silence. This shows that every row and column window decodes to its own code and that loss of edges drops the flag while the code holds. Random pairs detuned by up to 1 % are contrasted with pairs where one group is detuned by 6 %. The first set must decode and the second must not, which pins down the window edges between neighbouring tones. Further cases are a single-group tone, a burst shorter than the averaging span next to the same pair held long enough, and inhibit applied both before and during an extended character. These separate the two-group condition, the averaging latency and the column-3 block.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

   typedef enum logic {GRP_LOW = 1'b0, GRP_HIGH = 1'b1} tone_grp_e;

   // Nominal tone frequency for index 0..3 of a group, ascending
   function automatic int unsigned tone_hz(tone_grp_e grp, int unsigned k);
      int unsigned f;
      f = 0;
      if (grp == GRP_LOW) begin
         case (k)
            0: f = 697;
            1: f = 770;
            2: f = 852;
            default: f = 941;
         endcase
      end else begin
         case (k)
            0: f = 1209;
            1: f = 1336;
            2: f = 1477;
            default: f = 1633;
         endcase
      end
      return f;
   endfunction

   // Rounded reference cycles in one period of tone f
   function automatic int unsigned period_cycles(int unsigned ref_hz, int unsigned f);
      return (ref_hz + f / 2) / f;
   endfunction

   // Rounded reference cycles in navg periods of tone f
   function automatic int unsigned span_cycles(int unsigned ref_hz, int unsigned f,
                                               int unsigned navg);
      return (navg * ref_hz + f / 2) / f;
   endfunction

   // Half-width of an acceptance window in cycles
   function automatic int unsigned window_half(int unsigned nom, int unsigned permille);
      return (nom * permille + 500) / 1000;
   endfunction

endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tone_meter.sv
module tone_meter
   import dtmf_pkg::*;
#(
   parameter tone_grp_e   GROUP        = GRP_LOW,
   parameter int unsigned REF_HZ       = 3579545,
   parameter int unsigned NAVG         = 4,
   parameter int unsigned TOL_PERMILLE = 25,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tone_in,
   output logic       valid,
   output logic [1:0] idx
);
   localparam int unsigned TIMEOUT = 2 * period_cycles(REF_HZ, tone_hz(GROUP, 0));
   localparam int CNT_W  = $clog2(TIMEOUT + 1);
   localparam int SUM_W  = $clog2(NAVG * TIMEOUT + 1);
   localparam int NPER_W = $clog2(NAVG);

   logic              tone_s, tone_d, rise;
   logic              armed;
   logic [CNT_W-1:0]  cnt;
   logic [SUM_W-1:0]  sum, total;
   logic [NPER_W-1:0] nper;
   logic [3:0]        match;
   logic [1:0]        idx_n;

   tone_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(tone_in), .q(tone_s)
   );

   always_ff @(posedge clk) begin
      if (rst) tone_d <= 1'b0;
      else     tone_d <= tone_s;
   end
   assign rise  = tone_s && !tone_d;
   assign total = sum + SUM_W'(cnt);

   // One acceptance window per nominal tone of the group
   generate
      for (genvar g = 0; g < 4; g++) begin : g_win
         localparam int unsigned NOM = span_cycles(REF_HZ, tone_hz(GROUP, g), NAVG);
         localparam int unsigned LO  = NOM - window_half(NOM, TOL_PERMILLE);
         localparam int unsigned HI  = NOM + window_half(NOM, TOL_PERMILLE);
         assign match[g] = (32'(total) >= LO) && (32'(total) <= HI);
      end
   endgenerate

   always_comb begin
      idx_n = 2'd0;
      for (int k = 0; k < 4; k++)
         if (match[k]) idx_n = 2'(k);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         armed <= 1'b0;
         cnt   <= '0;
         sum   <= '0;
         nper  <= '0;
         valid <= 1'b0;
         idx   <= 2'd0;
      end else if (rise) begin
         cnt <= CNT_W'(1);
         if (!armed) begin
            armed <= 1'b1;
            sum   <= '0;
            nper  <= '0;
         end else if (nper == NPER_W'(NAVG - 1)) begin
            valid <= $onehot(match);
            idx   <= idx_n;
            sum   <= '0;
            nper  <= '0;
         end else begin
            sum  <= total;
            nper <= nper + NPER_W'(1);
         end
      end else if (armed) begin
         if (cnt == CNT_W'(TIMEOUT)) begin
            armed <= 1'b0;
            valid <= 1'b0;
            sum   <= '0;
            nper  <= '0;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/pair_decoder.sv
module pair_decoder (
   input  logic       clk,
   input  logic       rst,
   input  logic       lo_v,
   input  logic [1:0] lo_idx,
   input  logic       hi_v,
   input  logic [1:0] hi_idx,
   input  logic       inhibit,
   output logic       est,
   output logic [3:0] code
);
   logic extended, pair_ok;

   assign extended = (hi_idx == 2'd3);
   assign pair_ok  = lo_v && hi_v && !(inhibit && extended);

   always_ff @(posedge clk) begin
      if (rst) begin
         est  <= 1'b0;
         code <= 4'd0;
      end else begin
         est <= pair_ok;
         if (pair_ok) code <= {lo_idx, hi_idx};
      end
   end
endmodule

// File: rtl/dtmf_pair_decoder.sv
module dtmf_pair_decoder
   import dtmf_pkg::*;
#(
   parameter int unsigned REF_HZ       = 3579545,
   parameter int unsigned NAVG         = 4,
   parameter int unsigned TOL_PERMILLE = 25,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       lo_tone,
   input  logic       hi_tone,
   input  logic       inhibit,
   output logic       est,
   output logic [3:0] code
);
   // Elaboration-time parameter checks
   generate
      if (NAVG < 2 || (NAVG & (NAVG - 1)) != 0) begin : g_bad_navg
         $error("NAVG must be a power of two, at least 2");
      end
      if (TOL_PERMILLE == 0 || TOL_PERMILLE > 49) begin : g_bad_tol
         $error("TOL_PERMILLE must be in 1..49");
      end
      if (SYNC_STAGES == 0) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (REF_HZ < 20 * tone_hz(GRP_HIGH, 3)) begin : g_bad_ref
         $error("REF_HZ too low for period counting");
      end
   endgenerate

   logic       lo_valid, hi_valid;
   logic [1:0] lo_idx, hi_idx;

   tone_meter #(
      .GROUP(GRP_LOW), .REF_HZ(REF_HZ), .NAVG(NAVG),
      .TOL_PERMILLE(TOL_PERMILLE), .SYNC_STAGES(SYNC_STAGES)
   ) u_low (
      .clk(clk), .rst(rst), .tone_in(lo_tone), .valid(lo_valid), .idx(lo_idx)
   );

   tone_meter #(
      .GROUP(GRP_HIGH), .REF_HZ(REF_HZ), .NAVG(NAVG),
      .TOL_PERMILLE(TOL_PERMILLE), .SYNC_STAGES(SYNC_STAGES)
   ) u_high (
      .clk(clk), .rst(rst), .tone_in(hi_tone), .valid(hi_valid), .idx(hi_idx)
   );

   pair_decoder u_dec (
      .clk(clk), .rst(rst),
      .lo_v(lo_valid), .lo_idx(lo_idx),
      .hi_v(hi_valid), .hi_idx(hi_idx),
      .inhibit(inhibit), .est(est), .code(code)
   );
endmodule

// File: rtl/dtmf_pair_decoder_chk.sv
module dtmf_pair_decoder_chk (
   input logic       clk,
   input logic       rst,
   input logic       inhibit,
   input logic       est,
   input logic [3:0] code,
   input logic       lo_v,
   input logic       hi_v
);
   // R1: reset clears flag and code
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (!est && code == 4'd0));

   // R3: flag only follows a cycle with both groups valid
   a_r3_needs_both: assert property (@(posedge clk) disable iff (rst)
      est |-> $past(lo_v && hi_v));

   // R4: loss of either group drops the flag
   a_r4_loss_drops: assert property (@(posedge clk) disable iff (rst)
      !(lo_v && hi_v) |=> !est);

   // R7: with inhibit, no column-3 code is flagged
   a_r7_inhibit_blocks: assert property (@(posedge clk) disable iff (rst)
      (est && $past(inhibit)) |-> (code[1:0] != 2'b11));

   // R8: code moves only together with the flag
   a_r8_code_hold: assert property (@(posedge clk) disable iff (rst)
      !$stable(code) |-> est);
endmodule

bind dtmf_pair_decoder dtmf_pair_decoder_chk u_chk (
   .clk(clk), .rst(rst), .inhibit(inhibit), .est(est), .code(code),
   .lo_v(lo_valid), .hi_v(hi_valid)
);

// File: tb/tb_dtmf_pair_decoder.sv
module tb_dtmf_pair_decoder;
   localparam int REF = 89489;

   logic       clk = 1'b0;
   logic       rst, lo_tone, hi_tone, inhibit;
   logic       est;
   logic [3:0] code;

   int errors = 0;
   int checks = 0;
   int lo_per = 0, hi_per = 0, lo_ph = 0, hi_ph = 0;
   bit est_seen = 0;
   int exp_code = 0;

   always #5 clk = ~clk;

   dtmf_pair_decoder #(
      .REF_HZ(REF), .NAVG(4), .TOL_PERMILLE(25), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst(rst), .lo_tone(lo_tone), .hi_tone(hi_tone),
      .inhibit(inhibit), .est(est), .code(code)
   );

   function automatic int row_hz(int r);
      case (r) 0: return 697; 1: return 770; 2: return 852; default: return 941; endcase
   endfunction
   function automatic int col_hz(int c);
      case (c) 0: return 1209; 1: return 1336; 2: return 1477; default: return 1633; endcase
   endfunction
   // Period in cycles of tone f detuned by dpct percent
   function automatic int per_of(int f, int dpct);
      int fd100;
      fd100 = f * (100 + dpct);
      return (REF * 100 + fd100 / 2) / fd100;
   endfunction

   // Tone generators, driven away from the active edge
   always @(negedge clk) begin
      if (lo_per == 0) begin lo_tone = 1'b0; lo_ph = 0; end
      else begin
         lo_tone = (lo_ph < lo_per / 2);
         lo_ph   = (lo_ph + 1 >= lo_per) ? 0 : lo_ph + 1;
      end
      if (hi_per == 0) begin hi_tone = 1'b0; hi_ph = 0; end
      else begin
         hi_tone = (hi_ph < hi_per / 2);
         hi_ph   = (hi_ph + 1 >= hi_per) ? 0 : hi_ph + 1;
      end
      if (est) est_seen = 1'b1;
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic play(int r, int c, int dl, int dh);
      lo_per   = per_of(row_hz(r), dl);
      hi_per   = per_of(col_hz(c), dh);
      est_seen = 1'b0;
      repeat (1400) @(negedge clk);
   endtask

   task automatic quiet();
      lo_per = 0;
      hi_per = 0;
      repeat (800) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd2024));
      rst = 1'b1; inhibit = 1'b0; lo_tone = 1'b0; hi_tone = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      @(negedge clk);
      chk("R1 est after reset", int'(est), 0);
      chk("R1 code after reset", int'(code), 0);

      // R2/R4/R8: all sixteen nominal pairs, each followed by silence
      for (int r = 0; r < 4; r++) begin
         for (int c = 0; c < 4; c++) begin
            play(r, c, 0, 0);
            exp_code = r * 4 + c;
            chk("R2 est on pair", int'(est), 1);
            chk("R2 code of pair", int'(code), exp_code);
            quiet();
            chk("R4 est after silence", int'(est), 0);
            chk("R8 code held after silence", int'(code), exp_code);
         end
      end

      // R5: random pairs detuned by up to 1 percent are accepted
      for (int n = 0; n < 12; n++) begin
         int r, c, dl, dh;
         r  = int'($urandom % 4);
         c  = int'($urandom % 4);
         dl = int'($urandom % 3) - 1;
         dh = int'($urandom % 3) - 1;
         play(r, c, dl, dh);
         exp_code = r * 4 + c;
         chk("R5 est within tolerance", int'(est), 1);
         chk("R5 code within tolerance", int'(code), exp_code);
         quiet();
      end

      // R5: one group detuned by 6 percent is rejected
      for (int n = 0; n < 6; n++) begin
         int r, c, d;
         r = int'($urandom % 4);
         c = int'($urandom % 4);
         d = ($urandom % 2 == 0) ? 6 : -6;
         if (n % 2 == 0) play(r, c, d, 0);
         else            play(r, c, 0, d);
         chk("R5 detuned pair rejected", int'(est_seen), 0);
         chk("R8 code held on reject", int'(code), exp_code);
         quiet();
      end

      // R3: one group alone never raises the flag
      est_seen = 1'b0;
      lo_per = per_of(row_hz(2), 0);
      repeat (1400) @(negedge clk);
      chk("R3 low group alone", int'(est_seen), 0);
      quiet();
      est_seen = 1'b0;
      hi_per = per_of(col_hz(1), 0);
      repeat (1400) @(negedge clk);
      chk("R3 high group alone", int'(est_seen), 0);
      quiet();

      // R6: short burst rejected, same pair held is accepted
      est_seen = 1'b0;
      lo_per = per_of(row_hz(0), 0);
      hi_per = per_of(col_hz(2), 0);
      repeat (300) @(negedge clk);
      quiet();
      chk("R6 short burst no flag", int'(est_seen), 0);
      play(0, 2, 0, 0);
      exp_code = 2;
      chk("R6 held pair flagged", int'(est), 1);
      chk("R6 held pair code", int'(code), exp_code);
      quiet();

      // R7: inhibit blocks column 3 only
      inhibit = 1'b1;
      play(1, 3, 0, 0);
      chk("R7 inhibited char no flag", int'(est_seen), 0);
      chk("R7 inhibited char code held", int'(code), exp_code);
      quiet();
      play(2, 1, 0, 0);
      exp_code = 9;
      chk("R7 normal char under inhibit", int'(est), 1);
      chk("R7 normal char code", int'(code), exp_code);
      quiet();
      inhibit = 1'b0;
      play(3, 3, 0, 0);
      exp_code = 15;
      chk("R7 extended char without inhibit", int'(est), 1);
      chk("R7 extended code", int'(code), exp_code);
      inhibit = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 inhibit drops flag", int'(est), 0);
      chk("R8 code held after inhibit", int'(code), exp_code);
      inhibit = 1'b0;
      quiet();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule